// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a forward-mapped page table with two levels. A request is presented once, for example after a translation cache misses. The walker then reads one outer entry and one inner entry through a single-beat memory read port, and reports either the physical address or a fault.

Pages are 1 KB. The virtual address is split, from the most significant end, into a 12-bit outer index, a 10-bit inner index and a 10-bit byte offset. A table base input gives the byte address of the outer table, and each entry is 4 bytes. The walk reports a fault when it reaches an entry that is not valid. It also reports a fault when a write meets an entry that does not grant write access, at either level.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready_o` is 1, and `mem_req_o` and `done_o` are 0.
- R2: A request is accepted only when `req_valid_i` and `req_ready_o` are both 1, and `req_ready_o` is 1 only while idle. A request raised during a walk is ignored and starts no walk. The address, the write flag and the table base are captured at acceptance, so later changes on those inputs do not alter the walk.
- R3: The cycle after acceptance, `mem_req_o` is 1 for one cycle with `mem_addr_o` = base + 4 * vaddr[31:20], computed modulo 2^32.
- R4: After a usable outer entry, `mem_req_o` is 1 for one cycle with `mem_addr_o` = frame(outer) * 1024 + 4 * vaddr[19:10], computed modulo 2^32. An entry is laid out as bit 0 = valid, bit 1 = writable, bits 31:10 = frame number.
- R5: Each read is a one-cycle `mem_req_o` pulse. The walker then waits any number of cycles (at least one) for `mem_rvalid_i`. A `mem_rvalid_i` that arrives while no read is outstanding is ignored.
- R6: When both entries are usable, `done_o` pulses with `fault_o` = 0 and `paddr_o` = {frame(inner), vaddr[9:0]}.
- R7: An entry with valid = 0 ends the walk with no further read. `done_o` pulses with `fault_o` = 1, `fault_cause_o` = 0 (invalid), and `fault_level_o` = 0 for the outer entry or 1 for the inner entry.
- R8: A write request that meets a valid entry with writable = 0 ends the walk with `fault_o` = 1, `fault_cause_o` = 1 (protection) and the level of that entry. A read ignores the writable bit, and an invalid entry reports invalid even when the writable bit is clear.
- R9: `done_o` lasts exactly one cycle, and `req_ready_o` is 1 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Request is a write access |
| ptbr_i | input | 32 | Byte address of the outer table |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the entry to read |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse: walk finished |
| paddr_o | output | 32 | Physical address, meaningful with done_o and no fault |
| fault_o | output | 1 | Walk ended in a fault, with done_o |
| fault_level_o | output | 1 | 0 outer entry, 1 inner entry |
| fault_cause_o | output | 1 | 0 invalid entry, 1 write to read-only |

## Verification
Walks are driven with read and write accesses over four kinds of table content. The first is a fully mapped page, which separates a correct translation from a wrong index split or a wrong base sum. The second and third put an invalid entry or a read-only entry at either level, which separates the level and cause codes and shows that invalid takes priority. The fourth uses all-ones indices and offset, which exposes a carry or truncation slip in the address sums. Memory latency varies from one to several cycles. Requests during a walk, a stray read response while idle and a table base changed mid-walk show that these inputs have no effect on the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_OUTER,
    ST_WT_OUTER,
    ST_RD_INNER,
    ST_WT_INNER,
    ST_DONE
  } walk_state_e;

  typedef enum logic {
    LVL_OUTER = 1'b0,
    LVL_INNER = 1'b1
  } walk_level_e;

  typedef enum logic {
    CAUSE_INVALID = 1'b0,
    CAUSE_PROT    = 1'b1
  } walk_cause_e;
endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int PTE_W   = 32,
  parameter int FRAME_W = 22,
  parameter int VLD_BIT = 0,
  parameter int WR_BIT  = 1
) (
  input  logic [PTE_W-1:0]   pte_i,
  input  logic               write_i,
  output logic               fault_o,
  output ptw_pkg::walk_cause_e cause_o,
  output logic [FRAME_W-1:0] frame_o
);
  logic vld, wr_ok;

  assign vld     = pte_i[VLD_BIT];
  assign wr_ok   = pte_i[WR_BIT];
  assign frame_o = pte_i[PTE_W-1 -: FRAME_W];

  // invalid wins over protection
  always_comb begin
    fault_o = 1'b0;
    cause_o = ptw_pkg::CAUSE_INVALID;
    if (!vld) begin
      fault_o = 1'b1;
    end else if (write_i && !wr_ok) begin
      fault_o = 1'b1;
      cause_o = ptw_pkg::CAUSE_PROT;
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W        = 32,
  parameter int OFF_W       = 10,
  parameter int P1_W        = 12,
  parameter int P2_W        = 10,
  parameter int FRAME_W     = 22,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic               sel_inner_i,
  input  logic [PA_W-1:0]    ptbr_i,
  input  logic [P1_W-1:0]    p1_i,
  input  logic [P2_W-1:0]    p2_i,
  input  logic [FRAME_W-1:0] base_frame_i,
  output logic [PA_W-1:0]    addr_o
);
  localparam int IDX_W = (P1_W > P2_W ? P1_W : P2_W) + ENTRY_SHIFT;

  logic [PA_W-1:0] table_base;
  logic [IDX_W-1:0] idx_off;

  always_comb begin
    if (sel_inner_i) begin
      table_base = PA_W'({base_frame_i, {OFF_W{1'b0}}});
      idx_off    = IDX_W'({p2_i, {ENTRY_SHIFT{1'b0}}});
    end else begin
      table_base = ptbr_i;
      idx_off    = IDX_W'({p1_i, {ENTRY_SHIFT{1'b0}}});
    end
  end

  assign addr_o = table_base + PA_W'(idx_off);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 rvalid_i,
  input  logic                 pte_fault_i,
  output ptw_pkg::walk_state_e state_o,
  output logic                 accept_o,
  output logic                 take_outer_o,
  output logic                 take_inner_o,
  output logic                 sel_inner_o
);
  import ptw_pkg::*;

  walk_state_e state_q, state_d;

  assign accept_o     = (state_q == ST_IDLE) && req_valid_i;
  assign take_outer_o = (state_q == ST_WT_OUTER) && rvalid_i;
  assign take_inner_o = (state_q == ST_WT_INNER) && rvalid_i;
  assign sel_inner_o  = (state_q == ST_RD_INNER) || (state_q == ST_WT_INNER);
  assign state_o      = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_RD_OUTER;
      ST_RD_OUTER: state_d = ST_WT_OUTER;
      ST_WT_OUTER: if (rvalid_i) state_d = pte_fault_i ? ST_DONE : ST_RD_INNER;
      ST_RD_INNER: state_d = ST_WT_INNER;
      ST_WT_INNER: if (rvalid_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P1_W  = 12,
  parameter int PTE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic [PA_W-1:0]  ptbr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             fault_o,
  output logic             fault_level_o,
  output logic             fault_cause_o
);
  import ptw_pkg::*;

  localparam int P2_W        = VA_W - P1_W - OFF_W;
  localparam int FRAME_W     = PA_W - OFF_W;
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  walk_state_e          state;
  logic                 accept, take_outer, take_inner, sel_inner;
  logic                 pte_fault;
  walk_cause_e          pte_cause;
  logic [FRAME_W-1:0]   pte_frame;

  logic [VA_W-1:0]      va_q;
  logic                 wr_q;
  logic [PA_W-1:0]      ptbr_q;
  logic [FRAME_W-1:0]   base_q;
  logic [FRAME_W-1:0]   frame_q;
  logic                 fault_q;
  walk_level_e          level_q;
  walk_cause_e          cause_q;

  ptw_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .rvalid_i     (mem_rvalid_i),
    .pte_fault_i  (pte_fault),
    .state_o      (state),
    .accept_o     (accept),
    .take_outer_o (take_outer),
    .take_inner_o (take_inner),
    .sel_inner_o  (sel_inner)
  );

  ptw_pte_check #(
    .PTE_W   (PTE_W),
    .FRAME_W (FRAME_W)
  ) u_pte_check (
    .pte_i   (mem_rdata_i),
    .write_i (wr_q),
    .fault_o (pte_fault),
    .cause_o (pte_cause),
    .frame_o (pte_frame)
  );

  ptw_addr_gen #(
    .PA_W        (PA_W),
    .OFF_W       (OFF_W),
    .P1_W        (P1_W),
    .P2_W        (P2_W),
    .FRAME_W     (FRAME_W),
    .ENTRY_SHIFT (ENTRY_SHIFT)
  ) u_addr_gen (
    .sel_inner_i  (sel_inner),
    .ptbr_i       (ptbr_q),
    .p1_i         (va_q[VA_W-1 -: P1_W]),
    .p2_i         (va_q[OFF_W +: P2_W]),
    .base_frame_i (base_q),
    .addr_o       (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q    <= '0;
      wr_q    <= 1'b0;
      ptbr_q  <= '0;
      base_q  <= '0;
      frame_q <= '0;
      fault_q <= 1'b0;
      level_q <= LVL_OUTER;
      cause_q <= CAUSE_INVALID;
    end else begin
      if (accept) begin
        va_q    <= req_vaddr_i;
        wr_q    <= req_write_i;
        ptbr_q  <= ptbr_i;
        fault_q <= 1'b0;
      end
      if (take_outer) begin
        level_q <= LVL_OUTER;
        cause_q <= pte_cause;
        fault_q <= pte_fault;
        base_q  <= pte_frame;
      end
      if (take_inner) begin
        level_q <= LVL_INNER;
        cause_q <= pte_cause;
        fault_q <= pte_fault;
        frame_q <= pte_frame;
      end
    end
  end

  assign req_ready_o   = (state == ST_IDLE);
  assign mem_req_o     = (state == ST_RD_OUTER) || (state == ST_RD_INNER);
  assign done_o        = (state == ST_DONE);
  assign fault_o       = done_o && fault_q;
  assign fault_level_o = done_o && fault_q && (level_q == LVL_INNER);
  assign fault_cause_o = done_o && fault_q && (cause_q == CAUSE_PROT);
  assign paddr_o       = (done_o && !fault_q) ? {frame_q, va_q[OFF_W-1:0]} : '0;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 10,
  parameter int P1_W  = 12,
  parameter int PTE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic [PA_W-1:0]  ptbr_i,
  input logic             mem_req_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic             done_o,
  input logic             fault_o,
  input logic             fault_level_o,
  input logic             fault_cause_o
);
  localparam int ENTRY_SHIFT = $clog2(PTE_W / 8);

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_req_o && !done_o); // R2

  AST_OUTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> mem_req_o &&
      mem_addr_o == $past(ptbr_i) + PA_W'({$past(req_vaddr_i[VA_W-1 -: P1_W]), {ENTRY_SHIFT{1'b0}}})); // R3

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o && !done_o); // R5

  AST_FAULT_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o || fault_level_o || fault_cause_o) |-> done_o); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && req_ready_o); // R9
endmodule

bind ptw_walker ptw_walker_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W),
  .P1_W  (P1_W),
  .PTE_W (PTE_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_vaddr_i   (req_vaddr_i),
  .ptbr_i        (ptbr_i),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_level_o (fault_level_o),
  .fault_cause_o (fault_cause_o)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [31:0] ptbr = 32'h0010_0000;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [31:0] paddr;
  logic        fault, fault_level, fault_cause;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_vaddr), .req_write_i(req_write), .ptbr_i(ptbr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .done_o(done), .paddr_o(paddr), .fault_o(fault),
    .fault_level_o(fault_level), .fault_cause_o(fault_cause)
  );

  // table memory: bit0 valid, bit1 writable, [31:10] frame
  bit [31:0] mem [bit [31:0]];
  function automatic bit [31:0] rd(bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  function automatic bit [31:0] pte(bit [21:0] fr, bit w, bit v);
    return {fr, 8'h00, w, v};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // memory responder
  int lat_cfg = 1;
  int spur_req = 0, spur_done = 0;
  bit pend = 0;
  int pend_cnt = 0;
  bit [31:0] pend_addr;
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = rd(pend_addr);
        pend = 0;
      end else pend_cnt--;
    end else if (spur_req != spur_done) begin
      mem_rvalid = 1'b1;
      mem_rdata  = 32'hFFFF_FC03;
      spur_done++;
    end
    if (rst_n && mem_req === 1'b1) begin
      pend = 1; pend_addr = mem_addr; pend_cnt = lat_cfg - 1;
    end
  end

  // behavioural reference: phase 0 idle,1 rd outer,2 wait outer,3 rd inner,4 wait inner,5 done
  int m_st = 0;
  bit [31:0] m_va, m_ptbr, m_pa;
  bit m_wr, m_fault, m_lvl, m_cause;
  bit [21:0] m_base;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_st = 0;
    else begin
      case (m_st)
        0: if (req_valid) begin
             m_va = req_vaddr; m_wr = req_write; m_ptbr = ptbr; m_fault = 0; m_st = 1;
           end
        1: m_st = 2;
        2: if (mem_rvalid) begin
             m_lvl = 0;
             if (!mem_rdata[0]) begin m_fault = 1; m_cause = 0; m_st = 5; end
             else if (m_wr && !mem_rdata[1]) begin m_fault = 1; m_cause = 1; m_st = 5; end
             else begin m_base = mem_rdata[31:10]; m_st = 3; end
           end
        3: m_st = 4;
        4: if (mem_rvalid) begin
             m_lvl = 1;
             if (!mem_rdata[0]) begin m_fault = 1; m_cause = 0; end
             else if (m_wr && !mem_rdata[1]) begin m_fault = 1; m_cause = 1; end
             else m_pa = {mem_rdata[31:10], m_va[9:0]};
             m_st = 5;
           end
        default: m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 ready", req_ready, 32'(m_st == 0));
      chk("R5 mem_req", mem_req, 32'(m_st == 1 || m_st == 3));
      if (m_st == 1) chk("R3 outer addr", mem_addr, m_ptbr + {20'h0, m_va[31:20], 2'b00});
      if (m_st == 3) chk("R4 inner addr", mem_addr, {m_base, 10'h0} + {20'h0, m_va[19:10], 2'b00});
      chk("R9 done", done, 32'(m_st == 5));
      if (m_st == 5) begin
        chk("R7 fault", fault, 32'(m_fault));
        if (m_fault) begin
          chk("R7 level", fault_level, 32'(m_lvl));
          chk("R8 cause", fault_cause, 32'(m_cause));
        end else chk("R6 paddr", paddr, m_pa);
      end
    end
  end

  // directed walk with its own expectation
  task automatic walk(string req, bit [31:0] va, bit wr, int lat, bit exp_f, bit exp_l,
                      bit exp_c, bit [31:0] exp_pa, bit poke_busy, bit poke_ptbr);
    int n = 0;
    lat_cfg = lat;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    if (poke_ptbr) ptbr = 32'h00AB_0000;
    @(negedge clk);
    if (poke_busy) begin
      req_valid = 1; req_vaddr = 32'h0070_0000; req_write = 1;
      @(negedge clk);
      req_valid = 0;
    end
    while (done !== 1'b1 && n < 50) begin @(negedge clk); n++; end
    chk({req, " done seen"}, done, 1);
    chk({req, " fault"}, fault, exp_f);
    if (exp_f) begin
      chk({req, " level"}, fault_level, exp_l);
      chk({req, " cause"}, fault_cause, exp_c);
    end else chk({req, " paddr"}, paddr, exp_pa);
    ptbr = 32'h0010_0000;
    @(negedge clk);
    chk("R9 ready after done", req_ready, 1);
    chk("R2 no extra walk", mem_req, 0);
  endtask

  initial begin
    mem[32'h0010_000C] = pte(22'h200, 1, 1);               // p1=3
    mem[32'h0008_0014] = pte(22'h1234, 0, 1);              // p2=5, read-only
    mem[32'h0010_0024] = pte(22'h300, 0, 1);               // p1=9 read-only outer
    mem[32'h0010_0028] = pte(22'h001, 0, 0);               // p1=10 invalid, not writable
    mem[32'h0010_0010] = pte(22'h210, 1, 1);               // p1=4
    mem[32'h0008_4008] = pte(22'h0ABC, 1, 1);              // p2=2 writable
    mem[32'h0010_3FFC] = pte(22'h3FF00, 1, 1);             // p1=0xFFF
    mem[32'h0FFC_0FFC] = pte(22'h3FFFFF, 1, 1);            // p2=0x3FF
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 no req in reset", mem_req, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 done", done, 0);

    walk("R6 read hit", {12'd3, 10'd5, 10'h02A}, 0, 1, 0, 0, 0, {22'h1234, 10'h02A}, 0, 0);
    walk("R5 slow read", {12'd3, 10'd5, 10'h155}, 0, 6, 0, 0, 0, {22'h1234, 10'h155}, 1, 1);
    walk("R8 inner prot", {12'd3, 10'd5, 10'h000}, 1, 2, 1, 1, 1, 0, 0, 0);
    walk("R7 outer invalid", {12'd7, 10'd0, 10'h000}, 0, 1, 1, 0, 0, 0, 0, 0);
    walk("R8 outer prot", {12'd9, 10'd1, 10'h000}, 1, 3, 1, 0, 1, 0, 0, 0);
    walk("R7 inner invalid", {12'd9, 10'd1, 10'h000}, 0, 1, 1, 1, 0, 0, 0, 0);
    walk("R8 invalid first", {12'd10, 10'd0, 10'h000}, 1, 1, 1, 0, 0, 0, 0, 0);
    walk("R6 write ok", {12'd4, 10'd2, 10'h3C1}, 1, 4, 0, 0, 0, {22'h0ABC, 10'h3C1}, 0, 0);
    walk("R4 max idx", 32'hFFFF_FFFF, 1, 2, 0, 0, 0, 32'hFFFF_FFFF, 0, 0);

    spur_req++;
    repeat (3) @(negedge clk);
    chk("R5 stray rvalid no done", done, 0);
    chk("R5 stray rvalid idle", req_ready, 1);
    walk("R5 after stray", {12'd3, 10'd5, 10'h001}, 0, 1, 0, 0, 0, {22'h1234, 10'h001}, 0, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule